// File: doc/BRIEF.md
# Four-Way Cuckoo Block Mapper

This block is a hardware key-value table for a disk write cache. The key is a disk logical block number and the value is the number of the cache block that holds its data. A client sends one command at a time on a valid/ready port: lookup, insert or delete. The block returns a single-cycle response that carries a hit flag, a status code, a key, a value and the number of relocations the command caused.

Storage is split into four ways. Each way is a synchronous-read RAM with one key/value record per slot and a valid bit per slot. Way w places a key at the slot given by a multiplicative hash with its own odd constant: the top index bits of the low key-width bits of key times the constant. The constants are 0x9E3779B1, 0x85EBCA77, 0xC2B2AE3D and 0x27D4EB2F. Each key therefore has four candidate slots, one in each way. A lookup reads all four candidates in parallel. An insert that finds all four candidates taken starts a displacement chain. The new record goes into way 0, and every record pushed out moves on to its slot in the next way, in the order 0, 1, 2, 3, 0.

The chain length is capped by a parameter (100 by default). When the cap is reached, the block stops and hands back the record that was left without a slot. It also raises a sticky flag telling the system that the table must be enlarged and rebuilt. That rebuild happens outside the block.

Top module: `cuckoo_map`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0, rehash_req is 0 and every key misses.
- R2: A lookup (cmd_op 0) or a delete (cmd_op 2) raises rsp_valid in the second cycle after the clock edge that accepted it, whether it hits or misses. A lookup hit gives rsp_hit 1, rsp_status 0 and the stored value. A lookup miss gives rsp_hit 0, rsp_status 1 and value 0.
- R3: An insert (cmd_op 1) of an absent key that has a free candidate slot responds with rsp_status 0, rsp_hit 0 and rsp_disp 0. Later lookups of that key return the new value.
- R4: An insert of a key already present replaces its value in place. It responds with rsp_status 2, rsp_hit 1, rsp_val equal to the previous value and rsp_disp 0.
- R5: An insert of an absent key whose four candidate slots are all full relocates resident records. It reports the number of relocations on rsp_disp, never more than the cap. After a successful chain, every key stored before the insert is still found with its value.
- R6: If a further relocation would exceed the cap, the insert stops. It responds with rsp_status 3 and rsp_disp equal to the cap, and rsp_key/rsp_val carry the record left without a slot. All other stored records stay retrievable. rehash_req goes to 1 and stays 1 until reset.
- R7: A delete of a present key removes it and responds with rsp_status 0, rsp_hit 1 and the removed value. A delete of an absent key responds with rsp_status 1 and rsp_hit 0, and leaves the table unchanged.
- R8: cmd_ready is low from the accepting edge until the response. rsp_valid is high for exactly one cycle per command.
- R9: cmd_op 3 behaves exactly as a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted on this edge if valid |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 delete, 3 lookup |
| cmd_key | input | KEY_W | Logical block number |
| cmd_val | input | VAL_W | Cache block number (insert only) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Key was found in the table |
| rsp_status | output | 2 | 0 done, 1 not found, 2 updated, 3 table full |
| rsp_key | output | KEY_W | Command key, or the record left without a slot on status 3 |
| rsp_val | output | VAL_W | Found, previous, removed or leftover value |
| rsp_disp | output | DISP_W | Relocations made by this command |
| rehash_req | output | 1 | Sticky: displacement cap was reached |

## Verification
The bench fills a small table until the displacement cap is reached. It then checks that the record reported as leftover is the only one missing. A design that wrote the carried record before testing the cap, or that lost a resident during the chain, would leave a key missing or report the wrong leftover. Updates to resident keys are mixed into random traffic. A design that treated an update as a fresh insert would then return a stale value or duplicate the key, and a later delete would not remove it. Lookups that miss are timed against lookups that hit, which exposes a miss path that takes a different number of cycles. Deletes of absent keys are followed by full lookup sweeps, so a delete that cleared a wrong slot shows up.

// File: rtl/cuckoo_map_pkg.sv
package cuckoo_map_pkg;
  localparam int NUM_WAYS  = 4;
  localparam int WAY_SEL_W = $clog2(NUM_WAYS);

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_DELETE = 2'd2,
    OP_PEEK   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RS_DONE    = 2'd0,
    RS_ABSENT  = 2'd1,
    RS_UPDATED = 2'd2,
    RS_FULL    = 2'd3
  } rsp_status_e;

  // one odd multiplier per way
  localparam logic [31:0] HASH_MULT [NUM_WAYS] = '{
    32'h9E3779B1, 32'h85EBCA77, 32'hC2B2AE3D, 32'h27D4EB2F
  };
endpackage

// File: rtl/cuckoo_hash_unit.sv
module cuckoo_hash_unit
  import cuckoo_map_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int IDX_W = 6
) (
  input  logic [KEY_W-1:0]                key,
  output logic [NUM_WAYS-1:0][IDX_W-1:0]  idx
);
  localparam int SHIFT = KEY_W - IDX_W;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    // top index bits of the truncated product
    assign idx[w] = IDX_W'((key * KEY_W'(HASH_MULT[w])) >> SHIFT);
  end
endmodule

// File: rtl/cuckoo_way_ram.sv
module cuckoo_way_ram #(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32,
  parameter int DEPTH = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WORD_W = KEY_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [KEY_W-1:0] rd_key,
  output logic [VAL_W-1:0] rd_val,
  output logic             rd_vld,
  input  logic             wr_en,
  input  logic             vld_clr,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic [DEPTH-1:0]  vld;

  // record storage: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_key, wr_val};
    rd_word <= mem[rd_addr];
  end

  // occupancy bits live in flops so reset can empty the table
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en)   vld[wr_addr] <= 1'b1;
      if (vld_clr) vld[wr_addr] <= 1'b0;
      rd_vld <= vld[rd_addr];
    end
  end

  assign {rd_key, rd_val} = rd_word;
endmodule

// File: rtl/cuckoo_map_ctrl.sv
module cuckoo_map_ctrl
  import cuckoo_map_pkg::*;
#(
  parameter int KEY_W    = 32,
  parameter int VAL_W    = 32,
  parameter int IDX_W    = 6,
  parameter int MAX_DISP = 100,
  parameter int DISP_W   = 7
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [1:0]                        cmd_op,
  input  logic [KEY_W-1:0]                  cmd_key,
  input  logic [VAL_W-1:0]                  cmd_val,
  output logic [KEY_W-1:0]                  hash_key,
  input  logic [NUM_WAYS-1:0][IDX_W-1:0]    hash_idx,
  input  logic [NUM_WAYS-1:0][KEY_W-1:0]    rd_key,
  input  logic [NUM_WAYS-1:0][VAL_W-1:0]    rd_val,
  input  logic [NUM_WAYS-1:0]               rd_vld,
  output logic [NUM_WAYS-1:0]               wr_en,
  output logic [NUM_WAYS-1:0]               vld_clr,
  output logic [NUM_WAYS-1:0][IDX_W-1:0]    wr_addr,
  output logic [KEY_W-1:0]                  wr_key,
  output logic [VAL_W-1:0]                  wr_val,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [1:0]                        rsp_status,
  output logic [KEY_W-1:0]                  rsp_key,
  output logic [VAL_W-1:0]                  rsp_val,
  output logic [DISP_W-1:0]                 rsp_disp,
  output logic                              rehash_req
);
  localparam logic [DISP_W-1:0] CAP = DISP_W'(MAX_DISP);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_KICK, S_KEVAL} state_e;

  state_e                          state;
  op_e                             op_q;
  logic [KEY_W-1:0]                key_q;
  logic [VAL_W-1:0]                val_q;
  logic [NUM_WAYS-1:0][IDX_W-1:0]  idx_q;
  logic [KEY_W-1:0]                carry_key;
  logic [VAL_W-1:0]                carry_val;
  logic [WAY_SEL_W-1:0]            tgt_way;
  logic [IDX_W-1:0]                kick_idx;
  logic [DISP_W-1:0]               disp_cnt;

  logic [NUM_WAYS-1:0]             hit_vec;
  logic                            hit_any;
  logic                            free_any;
  logic [WAY_SEL_W-1:0]            hit_way;
  logic [WAY_SEL_W-1:0]            free_way;

  assign cmd_ready = (state == S_IDLE);
  assign hash_key  = (state == S_KICK) ? carry_key : cmd_key;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_match
    assign hit_vec[w] = rd_vld[w] && (rd_key[w] == key_q);
  end

  assign hit_any  = |hit_vec;
  assign free_any = ~&rd_vld;

  // lowest-numbered hit and free way
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way  = WAY_SEL_W'(w);
      if (!rd_vld[w]) free_way = WAY_SEL_W'(w);
    end
  end

  // write-port steering
  always_comb begin
    wr_en   = '0;
    vld_clr = '0;
    wr_addr = idx_q;
    wr_key  = key_q;
    wr_val  = val_q;
    if (state == S_PROBE) begin
      if (op_q == OP_INSERT) begin
        if (hit_any)       wr_en[hit_way]  = 1'b1;
        else if (free_any) wr_en[free_way] = 1'b1;
      end else if (op_q == OP_DELETE && hit_any) begin
        vld_clr[hit_way] = 1'b1;
      end
    end else if (state == S_KEVAL) begin
      wr_key = carry_key;
      wr_val = carry_val;
      for (int w = 0; w < NUM_WAYS; w++) wr_addr[w] = kick_idx;
      if (!rd_vld[tgt_way] || disp_cnt != CAP) wr_en[tgt_way] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_LOOKUP;
      key_q      <= '0;
      val_q      <= '0;
      idx_q      <= '0;
      carry_key  <= '0;
      carry_val  <= '0;
      tgt_way    <= '0;
      kick_idx   <= '0;
      disp_cnt   <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_status <= RS_DONE;
      rsp_key    <= '0;
      rsp_val    <= '0;
      rsp_disp   <= '0;
      rehash_req <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q  <= op_e'(cmd_op);
            key_q <= cmd_key;
            val_q <= cmd_val;
            idx_q <= hash_idx;
            state <= S_PROBE;
          end
        end
        S_PROBE: begin
          rsp_key  <= key_q;
          rsp_disp <= '0;
          if (op_q == OP_INSERT) begin
            if (hit_any || free_any) begin
              rsp_valid  <= 1'b1;
              rsp_hit    <= hit_any;
              rsp_status <= hit_any ? RS_UPDATED : RS_DONE;
              rsp_val    <= hit_any ? rd_val[hit_way] : '0;
              state      <= S_IDLE;
            end else begin
              carry_key <= key_q;
              carry_val <= val_q;
              tgt_way   <= '0;
              disp_cnt  <= '0;
              state     <= S_KICK;
            end
          end else begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= hit_any;
            rsp_status <= hit_any ? RS_DONE : RS_ABSENT;
            rsp_val    <= hit_any ? rd_val[hit_way] : '0;
            state      <= S_IDLE;
          end
        end
        S_KICK: begin
          kick_idx <= hash_idx[tgt_way];
          state    <= S_KEVAL;
        end
        default: begin
          if (!rd_vld[tgt_way]) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_status <= RS_DONE;
            rsp_key    <= key_q;
            rsp_val    <= '0;
            rsp_disp   <= disp_cnt;
            state      <= S_IDLE;
          end else if (disp_cnt == CAP) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_status <= RS_FULL;
            rsp_key    <= carry_key;
            rsp_val    <= carry_val;
            rsp_disp   <= disp_cnt;
            rehash_req <= 1'b1;
            state      <= S_IDLE;
          end else begin
            carry_key <= rd_key[tgt_way];
            carry_val <= rd_val[tgt_way];
            tgt_way   <= tgt_way + 1'b1;
            disp_cnt  <= disp_cnt + 1'b1;
            state     <= S_KICK;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cuckoo_map.sv
module cuckoo_map
  import cuckoo_map_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int VAL_W     = 32,
  parameter int WAY_DEPTH = 64,
  parameter int MAX_DISP  = 100,
  localparam int IDX_W    = $clog2(WAY_DEPTH),
  localparam int DISP_W   = $clog2(MAX_DISP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic [VAL_W-1:0]  cmd_val,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_status,
  output logic [KEY_W-1:0]  rsp_key,
  output logic [VAL_W-1:0]  rsp_val,
  output logic [DISP_W-1:0] rsp_disp,
  output logic              rehash_req
);
  logic [KEY_W-1:0]                hash_key;
  logic [NUM_WAYS-1:0][IDX_W-1:0]  hash_idx;
  logic [NUM_WAYS-1:0][KEY_W-1:0]  rd_key;
  logic [NUM_WAYS-1:0][VAL_W-1:0]  rd_val;
  logic [NUM_WAYS-1:0]             rd_vld;
  logic [NUM_WAYS-1:0]             wr_en;
  logic [NUM_WAYS-1:0]             vld_clr;
  logic [NUM_WAYS-1:0][IDX_W-1:0]  wr_addr;
  logic [KEY_W-1:0]                wr_key;
  logic [VAL_W-1:0]                wr_val;

  cuckoo_hash_unit #(.KEY_W(KEY_W), .IDX_W(IDX_W)) hash_i (
    .key (hash_key),
    .idx (hash_idx)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    cuckoo_way_ram #(.KEY_W(KEY_W), .VAL_W(VAL_W), .DEPTH(WAY_DEPTH)) ram_i (
      .clk     (clk),
      .rst     (rst),
      .rd_addr (hash_idx[w]),
      .rd_key  (rd_key[w]),
      .rd_val  (rd_val[w]),
      .rd_vld  (rd_vld[w]),
      .wr_en   (wr_en[w]),
      .vld_clr (vld_clr[w]),
      .wr_addr (wr_addr[w]),
      .wr_key  (wr_key),
      .wr_val  (wr_val)
    );
  end

  cuckoo_map_ctrl #(
    .KEY_W(KEY_W), .VAL_W(VAL_W), .IDX_W(IDX_W),
    .MAX_DISP(MAX_DISP), .DISP_W(DISP_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_key    (cmd_key),
    .cmd_val    (cmd_val),
    .hash_key   (hash_key),
    .hash_idx   (hash_idx),
    .rd_key     (rd_key),
    .rd_val     (rd_val),
    .rd_vld     (rd_vld),
    .wr_en      (wr_en),
    .vld_clr    (vld_clr),
    .wr_addr    (wr_addr),
    .wr_key     (wr_key),
    .wr_val     (wr_val),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_status (rsp_status),
    .rsp_key    (rsp_key),
    .rsp_val    (rsp_val),
    .rsp_disp   (rsp_disp),
    .rehash_req (rehash_req)
  );
endmodule

// File: rtl/cuckoo_map_chk.sv
module cuckoo_map_chk #(
  parameter int MAX_DISP = 100,
  parameter int DISP_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [1:0]        rsp_status,
  input logic [DISP_W-1:0] rsp_disp,
  input logic              rehash_req
);
  assert_disp_cap_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_disp <= DISP_W'(MAX_DISP)));

  assert_full_at_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd3) |-> (rsp_disp == DISP_W'(MAX_DISP) && rehash_req && !rsp_hit));

  assert_update_in_place_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd2) |-> (rsp_disp == '0 && rsp_hit));

  assert_rehash_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    rehash_req |=> rehash_req);

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op != 2'd1) |=> !rsp_valid ##1 rsp_valid);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_no_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_absent_no_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd1) |-> !rsp_hit);
endmodule

bind cuckoo_map cuckoo_map_chk #(.MAX_DISP(MAX_DISP), .DISP_W(DISP_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_status (rsp_status),
  .rsp_disp   (rsp_disp),
  .rehash_req (rehash_req)
);

// File: tb/cuckoo_map_tb.sv
module cuckoo_map_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W      = 32;
  localparam int VAL_W      = 32;
  localparam int WAY_DEPTH  = 8;
  localparam int MAX_DISP   = 100;
  localparam int DISP_W     = $clog2(MAX_DISP + 1);
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = 2'd0;
  logic [KEY_W-1:0]  cmd_key = '0;
  logic [VAL_W-1:0]  cmd_val = '0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [1:0]        rsp_status;
  logic [KEY_W-1:0]  rsp_key;
  logic [VAL_W-1:0]  rsp_val;
  logic [DISP_W-1:0] rsp_disp;
  logic              rehash_req;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cuckoo_map #(.KEY_W(KEY_W), .VAL_W(VAL_W), .WAY_DEPTH(WAY_DEPTH), .MAX_DISP(MAX_DISP)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_key(cmd_key), .cmd_val(cmd_val), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_status(rsp_status), .rsp_key(rsp_key), .rsp_val(rsp_val), .rsp_disp(rsp_disp),
    .rehash_req(rehash_req)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // reference table
  logic [VAL_W-1:0] mdl [logic [KEY_W-1:0]];

  // captured response
  logic              r_hit;
  logic [1:0]        r_st;
  logic [KEY_W-1:0]  r_key;
  logic [VAL_W-1:0]  r_val;
  logic [DISP_W-1:0] r_disp;
  int                r_lat;
  bit                r_busy_ok;

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_key   = k;
    cmd_val   = v;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    r_lat     = 1;
    r_busy_ok = 1'b1;
    while (!rsp_valid) begin
      if (cmd_ready) r_busy_ok = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    r_hit  = rsp_hit;
    r_st   = rsp_status;
    r_key  = rsp_key;
    r_val  = rsp_val;
    r_disp = rsp_disp;
    @(negedge clk);
    if (rsp_valid) r_busy_ok = 1'b0;
  endtask

  // lookup checked against the reference table
  task automatic do_lookup(input logic [1:0] op, input logic [KEY_W-1:0] k, input string req);
    bit present;
    present = mdl.exists(k);
    send(op, k, '0);
    check(r_lat == 2, req, "lookup latency", r_lat, 2);
    if (present) begin
      check(r_hit && r_st == 2'd0 && r_val == mdl[k], req, "lookup hit value", {r_hit, r_st, r_val}, {1'b1, 2'd0, mdl[k]});
    end else begin
      check(!r_hit && r_st == 2'd1 && r_val == '0, req, "lookup miss", {r_hit, r_st, r_val}, {1'b0, 2'd1, 32'd0});
    end
  endtask

  task automatic do_insert(input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
    bit present;
    logic [VAL_W-1:0] old;
    present = mdl.exists(k);
    old = present ? mdl[k] : '0;
    send(2'd1, k, v);
    check(r_busy_ok, "R8", "ready low while busy / single pulse", r_busy_ok, 1);
    check(r_disp <= DISP_W'(MAX_DISP), "R5", "displacement bound", r_disp, MAX_DISP);
    if (present) begin
      check(r_st == 2'd2 && r_hit && r_val == old && r_disp == '0, "R4", "update in place",
            {r_st, r_hit, r_val, r_disp}, {2'd2, 1'b1, old, 7'd0});
      mdl[k] = v;
    end else if (r_st == 2'd3) begin
      check(r_disp == DISP_W'(MAX_DISP) && rehash_req, "R6", "full at cap", r_disp, MAX_DISP);
      mdl[k] = v;
      check(mdl.exists(r_key) && mdl[r_key] == r_val, "R6", "leftover was a stored record", r_val, mdl.exists(r_key) ? mdl[r_key] : 0);
      mdl.delete(r_key);
    end else begin
      check(r_st == 2'd0 && !r_hit, "R3", "fresh insert status", {r_st, r_hit}, {2'd0, 1'b0});
      mdl[k] = v;
    end
  endtask

  task automatic do_delete(input logic [KEY_W-1:0] k);
    bit present;
    present = mdl.exists(k);
    send(2'd2, k, '0);
    check(r_lat == 2, "R2", "delete latency", r_lat, 2);
    if (present) begin
      check(r_st == 2'd0 && r_hit && r_val == mdl[k], "R7", "delete present", {r_st, r_hit, r_val}, {2'd0, 1'b1, mdl[k]});
      mdl.delete(k);
    end else begin
      check(r_st == 2'd1 && !r_hit, "R7", "delete absent", {r_st, r_hit}, {2'd1, 1'b0});
    end
  endtask

  task automatic sweep(input string req);
    foreach (mdl[k]) do_lookup(2'd0, k, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finish_run();
  end

  logic [KEY_W-1:0] pool [16];

  initial begin
    int seen_full;
    int seen_disp;
    logic [KEY_W-1:0] leftover;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(cmd_ready && !rsp_valid && !rehash_req, "R1", "reset outputs",
          {cmd_ready, rsp_valid, rehash_req}, 3'b100);
    do_lookup(2'd0, 32'h0000_1234, "R1");
    do_lookup(2'd0, 32'h0000_0000, "R1");

    // R3 / R2 directed
    do_insert(32'h00AB_CDEF, 32'h0000_0011);
    check(r_disp == '0, "R3", "fresh insert displacement", r_disp, 0);
    do_lookup(2'd0, 32'h00AB_CDEF, "R2");

    // R4 update in place
    do_insert(32'h00AB_CDEF, 32'h0000_0022);
    do_lookup(2'd0, 32'h00AB_CDEF, "R4");

    // R9 reserved op acts as lookup
    do_lookup(2'd3, 32'h00AB_CDEF, "R9");
    do_lookup(2'd3, 32'h7777_0000, "R9");

    // R7 delete present then absent
    do_delete(32'h00AB_CDEF);
    do_lookup(2'd0, 32'h00AB_CDEF, "R7");
    do_delete(32'h00AB_CDEF);

    // random traffic over a small key pool
    for (int i = 0; i < 16; i++) pool[i] = $urandom();
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [KEY_W-1:0] k;
      sel = $urandom_range(0, 9);
      k = pool[$urandom_range(0, 15)];
      if (sel < 5)      do_insert(k, $urandom());
      else if (sel < 8) do_lookup(2'd0, k, "R2");
      else              do_delete(k);
    end
    sweep("R5");

    // fill until the displacement cap is reached
    seen_full = 0;
    seen_disp = 0;
    for (int i = 0; i < 200 && seen_full == 0; i++) begin
      logic [KEY_W-1:0] k;
      k = $urandom();
      do_insert(k, $urandom());
      if (r_st == 2'd0 && r_disp != '0) seen_disp++;
      if (r_st == 2'd3) begin
        seen_full = 1;
        leftover = r_key;
      end
    end
    check(seen_disp > 0, "R5", "displacing inserts succeeded", seen_disp, 1);
    check(seen_full == 1, "R6", "cap reached", seen_full, 1);
    check(rehash_req, "R6", "rehash flag raised", rehash_req, 1);
    sweep("R6");
    do_lookup(2'd0, leftover, "R6");

    // flag stays set through further traffic
    do_lookup(2'd0, pool[0], "R6");
    do_delete(leftover);
    check(rehash_req, "R6", "rehash flag held", rehash_req, 1);
    sweep("R7");

    finish_run();
  end
endmodule